// File: doc/BRIEF.md
# Multi-Level I/O Page-Table Walker

This block turns a DMA input address into a physical address. It walks an in-memory I/O page table that has 3, 4 or 5 levels and 4 KB pages. A start pulse loads four inputs: the root table pointer, the number of levels, the input address and a host-address-width mask. The walker then fetches one 8-byte entry per level. It begins at the top level and moves down one level at a time to level 0, and no level is ever skipped. Each level draws its 9-bit table index from its own fixed bit field of the input address.

Entries are fetched through a valid/ready read-request channel. The data comes back on a response channel that also carries an error flag, and only one read is in flight at a time. Every pointer taken from an entry is masked to the host address width, and its low 12 bits are forced to zero. The walk ends in one of two ways:
- a one-cycle `done` pulse, with the translated address;
- a one-cycle `fault` pulse, with a fault code that stays readable until the next walk begins.

Top module: `iopt_walker`

## Requirements
- R1: A walk with L levels (3 ≤ L ≤ 5) issues exactly L reads, one per level. The first read is for level L-1, and each later read is for the next lower level, down to level 0.
- R2: The table index at level l is the 9-bit field `dma_addr[12+9*l +: 9]`. This gives shifts of 12, 21, 30, 39 and 48 for levels 0 to 4.
- R3: Each read address is `(ptr & haw_mask & ~0xFFF) | (index << 3)`. Here `ptr` is `root_ptr` for the first read and the previous entry for every later read. Bits 11:0 of `haw_mask` have no effect, and every read address is 8-byte aligned.
- R4: When the level-0 entry is present, `done` pulses for one cycle. In that same cycle `phys_addr` becomes `(entry & haw_mask & ~0xFFF) | dma_addr[11:0]` and `fault_code` is 0.
- R5: A response with `mem_rsp_err` set ends the walk at once. `fault` pulses, `fault_code` becomes 1 (read failure), and no further read is issued.
- R6: An entry whose bits 1:0 (read and write permission) are both zero ends the walk. `fault` pulses, `fault_code` becomes 2 (not present), and no further read is issued.
- R7: A start with a level count outside 3..5 issues no read and leaves `busy` low. In the next cycle `fault` pulses and `fault_code` is 3 (bad level).
- R8: `mem_req_valid` is high only while `busy` is high. Once raised, it stays high with a stable `mem_req_addr` until `mem_req_ready` is seen. No new request is raised until the previous response has arrived.
- R9: For a valid level count, `busy` rises in the cycle after the start pulse and falls in the cycle in which `done` or `fault` pulses. `done` and `fault` are never high together, and neither is high while `busy` is high.
- R10: A start pulse that arrives while `busy` is high is ignored. It does not change the walk in progress or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins a walk (ignored while busy) |
| root_ptr | input | 64 | Pointer to the top-level table |
| walk_levels | input | 3 | Number of paging levels (3, 4 or 5) |
| dma_addr | input | 57 | Input address to translate |
| haw_mask | input | 64 | Host-address-width mask applied to every pointer |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 64 | Byte address of the 8-byte entry |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry returned by memory |
| mem_rsp_err | input | 1 | Read failed |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle pulse: translation complete |
| fault | output | 1 | One-cycle pulse: walk ended with a fault |
| fault_code | output | 2 | 0 none, 1 read failure, 2 not present, 3 bad level |
| phys_addr | output | 64 | Translated physical address |

## Verification
The assertions take three things for granted about the memory side:
- `mem_rsp_valid` pulses once for each accepted request;
- it arrives only after that request has been accepted;
- `start` is a single-cycle pulse.

The bench's memory model follows these rules. It accepts at most one request, returns its data after a chosen latency of zero to three cycles, and holds `mem_rsp_valid` low at all other times. It can also toggle `mem_req_ready` to make the walker hold a request. Start pulses are driven for exactly one cycle at a falling edge, including the stray pulse sent in the middle of a walk.

// File: rtl/walk_pkg.sv
package walk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } walk_st_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_READ   = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_LEVEL  = 2'd3
    } walk_flt_e;

endpackage

// File: rtl/walk_entry_addr.sv
module walk_entry_addr #(
    parameter int ADDR_W     = 64,
    parameter int MAX_LEVELS = 5,
    parameter int IDX_BITS   = 9,
    parameter int PAGE_BITS  = 12,
    parameter int LVL_W      = 3,
    parameter int ENT_SHIFT  = 3
) (
    input  logic [ADDR_W-1:0]              ptr,
    input  logic [ADDR_W-1:0]              mask,
    input  logic [LVL_W-1:0]               lvl,
    input  logic [IDX_BITS*MAX_LEVELS-1:0] va_hi,
    output logic [ADDR_W-1:0]              ent_addr
);
    localparam logic [ADDR_W-1:0] PAGE_CLR = {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

    logic [IDX_BITS-1:0] idx_tab [MAX_LEVELS];
    logic [IDX_BITS-1:0] idx_sel;

    // one fixed index slice per level
    for (genvar l = 0; l < MAX_LEVELS; l++) begin : g_idx
        assign idx_tab[l] = va_hi[IDX_BITS*l +: IDX_BITS];
    end

    always_comb begin
        idx_sel = '0;
        for (int l = 0; l < MAX_LEVELS; l++) begin
            if (lvl == LVL_W'(l)) begin
                idx_sel = idx_tab[l];
            end
        end
    end

    assign ent_addr = (ptr & mask & PAGE_CLR) | (ADDR_W'(idx_sel) << ENT_SHIFT);

endmodule

// File: rtl/walk_entry_decode.sv
module walk_entry_decode #(
    parameter int ADDR_W    = 64,
    parameter int PAGE_BITS = 12
) (
    input  logic [ADDR_W-1:0]    entry,
    input  logic [ADDR_W-1:0]    mask,
    input  logic [PAGE_BITS-1:0] page_off,
    output logic                 present,
    output logic [ADDR_W-1:0]    leaf_phys
);
    localparam logic [ADDR_W-1:0] PAGE_CLR = {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

    // bit 0 read permission, bit 1 write permission
    assign present   = entry[0] | entry[1];
    assign leaf_phys = (entry & mask & PAGE_CLR) | ADDR_W'(page_off);

endmodule

// File: rtl/iopt_walker.sv
module iopt_walker
    import walk_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int MIN_LEVELS = 3,
    parameter int MAX_LEVELS = 5,
    parameter int IDX_BITS   = 9,
    parameter int PAGE_BITS  = 12,
    parameter int LVL_W      = 3,
    parameter int VA_W       = PAGE_BITS + IDX_BITS * MAX_LEVELS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] root_ptr,
    input  logic [LVL_W-1:0]  walk_levels,
    input  logic [VA_W-1:0]   dma_addr,
    input  logic [ADDR_W-1:0] haw_mask,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [1:0]        fault_code,
    output logic [ADDR_W-1:0] phys_addr
);
    localparam int WALK_BITS = IDX_BITS * MAX_LEVELS;

    typedef struct packed {
        walk_st_e          st;
        logic [LVL_W-1:0]  lvl;
        logic [ADDR_W-1:0] ptr;
        logic [VA_W-1:0]   va;
        logic [ADDR_W-1:0] mask;
        logic [ADDR_W-1:0] phys;
        walk_flt_e         code;
        logic              done;
        logic              fault;
    } walk_state_t;

    walk_state_t s_d, s_q;

    logic              ent_present;
    logic [ADDR_W-1:0] ent_leaf;
    logic [ADDR_W-1:0] ent_addr;
    logic              lvl_ok;

    walk_entry_addr #(
        .ADDR_W(ADDR_W), .MAX_LEVELS(MAX_LEVELS), .IDX_BITS(IDX_BITS),
        .PAGE_BITS(PAGE_BITS), .LVL_W(LVL_W), .ENT_SHIFT(3)
    ) u_addr (
        .ptr     (s_q.ptr),
        .mask    (s_q.mask),
        .lvl     (s_q.lvl),
        .va_hi   (s_q.va[PAGE_BITS +: WALK_BITS]),
        .ent_addr(ent_addr)
    );

    walk_entry_decode #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)
    ) u_dec (
        .entry    (mem_rsp_data),
        .mask     (s_q.mask),
        .page_off (s_q.va[PAGE_BITS-1:0]),
        .present  (ent_present),
        .leaf_phys(ent_leaf)
    );

    assign lvl_ok = (walk_levels >= LVL_W'(MIN_LEVELS)) && (walk_levels <= LVL_W'(MAX_LEVELS));

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        s_d.fault = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.phys = '0;
                    if (!lvl_ok) begin
                        s_d.fault = 1'b1;
                        s_d.code  = FLT_LEVEL;
                    end else begin
                        s_d.st   = ST_REQ;
                        s_d.lvl  = walk_levels - LVL_W'(1);
                        s_d.ptr  = root_ptr;
                        s_d.va   = dma_addr;
                        s_d.mask = haw_mask;
                        s_d.code = FLT_NONE;
                    end
                end
            end
            ST_REQ: begin
                if (mem_req_ready) begin
                    s_d.st = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        s_d.st    = ST_IDLE;
                        s_d.fault = 1'b1;
                        s_d.code  = FLT_READ;
                    end else if (!ent_present) begin
                        s_d.st    = ST_IDLE;
                        s_d.fault = 1'b1;
                        s_d.code  = FLT_ABSENT;
                    end else if (s_q.lvl == '0) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                        s_d.phys = ent_leaf;
                    end else begin
                        s_d.st  = ST_REQ;
                        s_d.ptr = mem_rsp_data;
                        s_d.lvl = s_q.lvl - LVL_W'(1);
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_req_valid = (s_q.st == ST_REQ);
    assign mem_req_addr  = ent_addr;
    assign busy          = (s_q.st != ST_IDLE);
    assign done          = s_q.done;
    assign fault         = s_q.fault;
    assign fault_code    = s_q.code;
    assign phys_addr     = s_q.phys;

endmodule

// File: rtl/walk_chk.sv
module walk_chk #(
    parameter int ADDR_W     = 64,
    parameter int MIN_LEVELS = 3,
    parameter int MAX_LEVELS = 5,
    parameter int LVL_W      = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [LVL_W-1:0]  walk_levels,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              busy,
    input logic              done,
    input logic              fault,
    input logic [1:0]        fault_code
);
    logic lvl_bad;
    assign lvl_bad = (walk_levels < LVL_W'(MIN_LEVELS)) || (walk_levels > LVL_W'(MAX_LEVELS));

    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_req_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    assert_req_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[2:0] == 3'b000);

    assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !fault && !busy);

    assert_fault_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !busy);

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && !lvl_bad |=> busy);

    assert_bad_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy && lvl_bad |=> fault && !busy && fault_code == 2'd3);

    assert_done_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fault_code == 2'd0);

endmodule

bind iopt_walker walk_chk #(
    .ADDR_W(ADDR_W), .MIN_LEVELS(MIN_LEVELS), .MAX_LEVELS(MAX_LEVELS), .LVL_W(LVL_W)
) u_walk_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .walk_levels  (walk_levels),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_addr (mem_req_addr),
    .busy         (busy),
    .done         (done),
    .fault        (fault),
    .fault_code   (fault_code)
);

// File: tb/tb_iopt_walker.sv
module tb_iopt_walker;
    localparam int AW = 64;
    localparam int VW = 57;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] root_ptr = '0;
    logic [2:0]    walk_levels = '0;
    logic [VW-1:0] dma_addr = '0;
    logic [AW-1:0] haw_mask = '0;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [AW-1:0] mem_rsp_data = '0;
    logic          mem_rsp_err = 1'b0;
    logic          busy, done, fault;
    logic [1:0]    fault_code;
    logic [AW-1:0] phys_addr;

    iopt_walker dut (
        .clk(clk), .rst_n(rst_n), .start(start), .root_ptr(root_ptr),
        .walk_levels(walk_levels), .dma_addr(dma_addr), .haw_mask(haw_mask),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .mem_rsp_err(mem_rsp_err),
        .busy(busy), .done(done), .fault(fault), .fault_code(fault_code),
        .phys_addr(phys_addr)
    );

    always #2 clk = ~clk;

    // memory model
    logic [AW-1:0] mem [logic [AW-1:0]];
    logic [AW-1:0] req_log [16];
    int            req_n = 0;
    logic [AW-1:0] exp_log [8];
    logic          stall_mode = 1'b0;
    int            lat = 0;
    logic          err_en = 1'b0;
    logic [AW-1:0] err_addr = '0;
    logic          pend = 1'b0;
    int            cnt = 0;
    logic [AW-1:0] paddr = '0;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        mem_req_ready <= stall_mode ? ~mem_req_ready : 1'b1;
        if (mem_req_valid && mem_req_ready && !pend) begin
            pend  <= 1'b1;
            paddr <= mem_req_addr;
            cnt   <= lat;
            if (req_n < 16) req_log[req_n] <= mem_req_addr;
            req_n <= req_n + 1;
        end
        if (pend) begin
            if (cnt == 0) begin
                pend          <= 1'b0;
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= mem.exists(paddr) ? mem[paddr] : '0;
                mem_rsp_err   <= err_en && (paddr == err_addr);
            end else begin
                cnt <= cnt - 1;
            end
        end
    end

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung (actual %0d cycles, expected < 100000)", cycles);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] ent_addr(input logic [AW-1:0] p, input logic [AW-1:0] m,
                                               input int l, input logic [VW-1:0] va);
        logic [AW-1:0] idx;
        idx = AW'((va >> (12 + 9 * l)) & 57'h1FF);
        return (p & m & ~64'hFFF) | (idx << 3);
    endfunction

    // build a chain of tables; returns the expected leaf physical address
    task automatic build(input logic [AW-1:0] root, input int levels, input logic [VW-1:0] va,
                         input logic [AW-1:0] m, input logic [AW-1:0] leaf,
                         input logic [AW-1:0] base, output logic [AW-1:0] exp_phys);
        logic [AW-1:0] cur;
        mem.delete();
        cur = root;
        for (int i = 0; i < levels; i++) begin
            logic [AW-1:0] nxt;
            exp_log[i] = ent_addr(cur, m, levels - 1 - i, va);
            if (i == levels - 1) nxt = leaf;
            else nxt = (base + 64'(i) * 64'h1000) | 64'hF000_0000_0000_0000 | 64'h803;
            mem[exp_log[i]] = nxt;
            cur = nxt;
        end
        exp_phys = (leaf & m & ~64'hFFF) | AW'(va[11:0]);
    endtask

    task automatic launch(input logic [AW-1:0] root, input int levels, input logic [VW-1:0] va,
                          input logic [AW-1:0] m);
        @(negedge clk);
        req_n       = 0;
        root_ptr    = root;
        walk_levels = 3'(levels);
        dma_addr    = va;
        haw_mask    = m;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done || fault) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic walk_ok(input string tag, input int levels, input logic [VW-1:0] va,
                           input bit stl, input int l, input logic [AW-1:0] base);
        logic [AW-1:0] root, m, leaf, ep;
        bit ok;
        root = 64'h0000_0000_0100_0000 | base | 64'hABC;
        m    = 64'h0000_FFFF_FFFF_FFFF;
        leaf = 64'hF000_00AB_CDE0_0FF3;
        build(root, levels, va, m, leaf, base + 64'h10_0000, ep);
        stall_mode = stl;
        lat        = l;
        launch(root, levels, va, m);
        chk(busy == 1'b1, {tag, " R9 busy after start"}, 64'(busy), 64'd1);
        wait_end(ok);
        chk(ok && done && !fault, {tag, " R4 done pulse"}, 64'({done, fault}), 64'b10);
        chk(phys_addr == ep, {tag, " R4 physical address"}, phys_addr, ep);
        chk(fault_code == 2'd0, {tag, " R4 no fault code"}, 64'(fault_code), 64'd0);
        chk(busy == 1'b0, {tag, " R9 busy low at done"}, 64'(busy), 64'd0);
        chk(req_n == levels, {tag, " R1 read count"}, 64'(req_n), 64'(levels));
        for (int i = 0; i < levels; i++)
            chk(req_log[i] == exp_log[i], {tag, " R2 R3 entry address order"}, req_log[i], exp_log[i]);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R4 done is one cycle"}, 64'(done), 64'd0);
        stall_mode = 1'b0;
    endtask

    task automatic test_absent();
        logic [AW-1:0] ep;
        bit ok;
        build(64'h200000, 4, 57'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF, 64'h5003, 64'h300000, ep);
        mem[exp_log[1]] = mem[exp_log[1]] & ~64'h3;
        lat = 1;
        launch(64'h200000, 4, 57'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF);
        wait_end(ok);
        chk(ok && fault && !done, "R6 fault pulse", 64'({done, fault}), 64'b01);
        chk(fault_code == 2'd2, "R6 not-present code 2", 64'(fault_code), 64'd2);
        chk(req_n == 2, "R6 no read after absent entry", 64'(req_n), 64'd2);
    endtask

    task automatic test_read_err();
        logic [AW-1:0] ep;
        bit ok;
        build(64'h400000, 5, 57'h1AB_CDEF_0123_4567, 64'hFFFF_FFFF_FFFF, 64'h9001, 64'h500000, ep);
        err_en   = 1'b1;
        err_addr = exp_log[2];
        lat      = 2;
        launch(64'h400000, 5, 57'h1AB_CDEF_0123_4567, 64'hFFFF_FFFF_FFFF);
        wait_end(ok);
        chk(ok && fault && !done, "R5 fault pulse", 64'({done, fault}), 64'b01);
        chk(fault_code == 2'd1, "R5 read failure code 1", 64'(fault_code), 64'd1);
        chk(req_n == 3, "R5 no read after failure", 64'(req_n), 64'd3);
        err_en = 1'b0;
    endtask

    task automatic test_bad_level(input int levels);
        launch(64'h1000, levels, 57'h1234, 64'hFFFF_FFFF_FFFF);
        // fault pulses in the cycle after the start edge, seen at this negedge
        chk(fault && !done, "R7 bad level fault pulse", 64'({done, fault}), 64'b01);
        chk(fault_code == 2'd3, "R7 bad level code 3", 64'(fault_code), 64'd3);
        chk(busy == 1'b0, "R7 busy stays low", 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        chk(req_n == 0, "R7 no read issued", 64'(req_n), 64'd0);
    endtask

    task automatic test_start_ignored();
        logic [AW-1:0] ep;
        bit ok;
        build(64'h600000, 4, 57'h00F_0F0F_0F0F_0F0F, 64'hFF_FFFF_FFFF, 64'h7_7777_7002, 64'h700000, ep);
        lat = 3;
        launch(64'h600000, 4, 57'h00F_0F0F_0F0F_0F0F, 64'hFF_FFFF_FFFF);
        repeat (3) @(negedge clk);
        root_ptr    = 64'h9999_0000;
        walk_levels = 3'd3;
        dma_addr    = 57'h0;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_end(ok);
        chk(ok && done, "R10 walk completes despite stray start", 64'(done), 64'd1);
        chk(phys_addr == ep, "R10 result unchanged", phys_addr, ep);
        chk(req_n == 4, "R10 read count unchanged", 64'(req_n), 64'd4);
        chk(req_log[0] == exp_log[0], "R10 first address from original root", req_log[0], exp_log[0]);
        @(negedge clk);
        chk(busy == 1'b0, "R10 no walk started by stray pulse", 64'(busy), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && fault == 1'b0, "R9 reset outputs low",
            64'({busy, done, fault}), 64'd0);
        chk(mem_req_valid == 1'b0, "R8 no request in reset", 64'(mem_req_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fault_code == 2'd0 && phys_addr == '0, "R4 reset result cleared",
            64'(fault_code) | phys_addr, 64'd0);

        walk_ok("4-level", 4, 57'h0_1234_5678_9ABC, 1'b0, 0, 64'h0100_0000);
        walk_ok("3-level stalled", 3, 57'h1FF_FFFF_FFFF_FFFF, 1'b1, 1, 64'h0200_0000);
        walk_ok("5-level", 5, 57'h155_5555_5555_5AAA, 1'b0, 2, 64'h0300_0000);
        walk_ok("5-level stalled", 5, 57'h0AA_AAAA_AAAA_A555, 1'b1, 3, 64'h0400_0000);
        test_absent();
        test_read_err();
        test_bad_level(2);
        test_bad_level(6);
        test_bad_level(0);
        test_start_ignored();
        report();
    end

endmodule